// File: doc/BRIEF.md
# Spike-Timing Learning Synapse with Rate Homeostasis

This block is the learning logic of one synapse. It holds an unsigned weight and adjusts it from three clocked strobes: a presynaptic spike, a postsynaptic spike and a time-base tick. A pairing rule strengthens the weight when the presynaptic side fired shortly before the postsynaptic side. It weakens the weight when the order is reversed. A slow negative-feedback loop counts postsynaptic spikes over a programmable number of ticks and moves the weight toward a target firing rate. A leak term lowers the weight by one LSB at a fixed tick interval. The result is always clamped between a programmable floor and ceiling.

Each side keeps a saturating 8-bit age, in ticks, since its own last spike. After reset both ages start at 255, which counts as "no spike seen". All contributions that fire in the same clock cycle are summed. The sum is then clamped once and registered, so the weight changes one cycle after the triggering strobe.

Top module: `plastic_synapse`

## Requirements
- R1: While reset is asserted and right after it is released, `weight` equals the parameter `RESET_WEIGHT` (default 128), and both ages read as 255.
- R2: A `postSpike` cycle without `preSpike` adds `cfgStepUp` to the weight when the presynaptic age is strictly less than `cfgWindow`.
- R3: A `preSpike` cycle without `postSpike` subtracts `cfgStepDown` from the weight when the postsynaptic age is strictly less than `cfgWindow`.
- R4: A `tick` raises each age by one, saturating at 255. A spike on a side sets that side's age to 0, and the spike wins over a tick in the same cycle. A spike whose partner age is equal to or greater than `cfgWindow` leaves the weight unchanged.
- R5: When `preSpike` and `postSpike` are both high in the same cycle, the pairing rule makes no change, though both ages still restart at 0.
- R6: After any update the weight lies within [`cfgWeightMin`, `cfgWeightMax`]. A result above the ceiling becomes the ceiling, and a result below the floor becomes the floor.
- R7: `atMax` is high exactly when the weight equals `cfgWeightMax`. `atMin` is high exactly when the weight equals `cfgWeightMin`.
- R8: When `cfgRatePeriod` is nonzero, the tick that completes each period compares the period's postSpike count, including a spike in that same cycle, with `cfgSetPoint`. If the count is greater, the weight drops by `cfgHomeoStep`. If it is smaller, the weight rises by `cfgHomeoStep`. If they are equal, there is no change. The count then restarts.
- R9: When `cfgDecayPeriod` is N > 0, every Nth tick lowers the weight by one LSB, never below `cfgWeightMin`. When N = 0, or when `cfgRatePeriod` = 0, that mechanism is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| preSpike | input | 1 | Presynaptic spike strobe |
| postSpike | input | 1 | Postsynaptic spike strobe |
| tick | input | 1 | Time-base strobe |
| cfgStepUp | input | W | Potentiation step |
| cfgStepDown | input | W | Depression step |
| cfgWindow | input | 8 | Pairing window in ticks (exclusive) |
| cfgWeightMin | input | W | Weight floor |
| cfgWeightMax | input | W | Weight ceiling |
| cfgSetPoint | input | CW | Target postSpike count per rate period |
| cfgHomeoStep | input | W | Homeostatic step |
| cfgRatePeriod | input | CW | Ticks per rate period, 0 disables |
| cfgDecayPeriod | input | CW | Ticks per decay LSB, 0 disables |
| weight | output | W | Current weight |
| atMax | output | 1 | Weight equals ceiling |
| atMin | output | 1 | Weight equals floor |

## Verification
The bench goes after the exact window edge, where an age equal to `cfgWindow` must not pair. A `<=` comparator would wrongly potentiate there. It also applies coincident pre and post spikes right after a post spike: a design that lets the pre side win would depress instead of holding. The homeostatic period is driven over, under and exactly at the set point. A swapped comparison shows up as the weight moving the wrong way, and an inclusive test as a step on the equal case. Finally, decay runs into the floor and large steps overshoot both bounds. A missing clamp shows up as wrap-around or a weight below the floor.

// File: rtl/synPkg.sv
package synPkg;
  typedef struct packed {
    logic ltp;
    logic ltd;
    logic homeoUp;
    logic homeoDown;
    logic decay;
  } learnStrobes_t;
endpackage

// File: rtl/syn_ctrl.sv
module syn_ctrl import synPkg::*; #(
  parameter int AGE_W = 8,
  parameter int CW    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             preSpike,
  input  logic             postSpike,
  input  logic             tick,
  input  logic [AGE_W-1:0] cfgWindow,
  input  logic [CW-1:0]    cfgSetPoint,
  input  logic [CW-1:0]    cfgRatePeriod,
  input  logic [CW-1:0]    cfgDecayPeriod,
  output learnStrobes_t    strobes
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
  localparam logic [CW-1:0]    CNT_MAX = {CW{1'b1}};

  logic [AGE_W-1:0] preAge, postAge;
  logic [CW-1:0]    rateTicks, postCount, decayTicks;
  logic [CW:0]      effCount;
  logic             rateEnd, decayEnd;

  // Ages since each side's last spike; a spike restarts the age, a tick advances it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preAge  <= AGE_MAX;
      postAge <= AGE_MAX;
    end else begin
      if (preSpike)                     preAge <= '0;
      else if (tick && preAge != AGE_MAX) preAge <= preAge + 1'b1;
      if (postSpike)                     postAge <= '0;
      else if (tick && postAge != AGE_MAX) postAge <= postAge + 1'b1;
    end
  end

  assign rateEnd  = tick && (cfgRatePeriod != '0) &&
                    ({1'b0, rateTicks} + 1'b1 >= {1'b0, cfgRatePeriod});
  assign decayEnd = tick && (cfgDecayPeriod != '0) && (cfgRatePeriod != '0) &&
                    ({1'b0, decayTicks} + 1'b1 >= {1'b0, cfgDecayPeriod});
  assign effCount = {1'b0, postCount} + {{CW{1'b0}}, postSpike};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateTicks  <= '0;
      postCount  <= '0;
      decayTicks <= '0;
    end else begin
      if (cfgRatePeriod == '0 || rateEnd) begin
        rateTicks <= '0;
        postCount <= '0;
      end else begin
        if (tick) rateTicks <= rateTicks + 1'b1;
        if (postSpike && postCount != CNT_MAX) postCount <= postCount + 1'b1;
      end
      if (cfgDecayPeriod == '0 || cfgRatePeriod == '0 || decayEnd) decayTicks <= '0;
      else if (tick) decayTicks <= decayTicks + 1'b1;
    end
  end

  always_comb begin
    strobes.ltp       = postSpike && !preSpike && (preAge < cfgWindow);
    strobes.ltd       = preSpike && !postSpike && (postAge < cfgWindow);
    strobes.homeoUp   = rateEnd && (effCount < {1'b0, cfgSetPoint});
    strobes.homeoDown = rateEnd && (effCount > {1'b0, cfgSetPoint});
    strobes.decay     = decayEnd;
  end

  // R5: coincident spikes never produce a pairing strobe
  p_pair_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    (preSpike && postSpike) |-> !(strobes.ltp || strobes.ltd));
  // R8: the rate loop never pushes both ways at once
  p_homeo_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.homeoUp, strobes.homeoDown}));
  // R4: an age at its ceiling stays there without a spike on that side
  p_age_sat_r4: assert property (@(posedge clk) disable iff (!rstN)
    (preAge == AGE_MAX && !preSpike) |=> preAge == AGE_MAX);
endmodule

// File: rtl/syn_datapath.sv
module syn_datapath import synPkg::*; #(
  parameter int W = 8,
  parameter logic [W-1:0] RESET_WEIGHT = 8'd128
) (
  input  logic          clk,
  input  logic          rstN,
  input  learnStrobes_t strobes,
  input  logic [W-1:0]  cfgStepUp,
  input  logic [W-1:0]  cfgStepDown,
  input  logic [W-1:0]  cfgHomeoStep,
  input  logic [W-1:0]  cfgWeightMin,
  input  logic [W-1:0]  cfgWeightMax,
  output logic [W-1:0]  weight
);
  localparam int SW = W + 3;

  logic signed [SW-1:0] sum, lo, hi;
  logic [W-1:0]         nextWeight;

  function automatic logic signed [SW-1:0] ext(input logic [W-1:0] v);
    return $signed({3'b000, v});
  endfunction

  always_comb begin
    sum = ext(weight);
    if (strobes.ltp)       sum = sum + ext(cfgStepUp);
    if (strobes.ltd)       sum = sum - ext(cfgStepDown);
    if (strobes.homeoUp)   sum = sum + ext(cfgHomeoStep);
    if (strobes.homeoDown) sum = sum - ext(cfgHomeoStep);
    if (strobes.decay)     sum = sum - ext(W'(1));
    lo = ext(cfgWeightMin);
    hi = ext(cfgWeightMax);
    if (sum > hi)      nextWeight = cfgWeightMax;
    else               nextWeight = sum[W-1:0];
    if (sum < lo)      nextWeight = cfgWeightMin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) weight <= RESET_WEIGHT;
    else       weight <= nextWeight;
  end

  // R6: weight lands inside the bounds that were in force
  p_bounds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWeightMin <= cfgWeightMax) |=>
      (weight >= $past(cfgWeightMin) && weight <= $past(cfgWeightMax)));
  // R4: no learning strobe and an in-range weight means the weight holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0 && weight >= cfgWeightMin && weight <= cfgWeightMax) |=> $stable(weight));
  // R2: a lone potentiation inside the bounds adds exactly one step
  p_ltp_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == 5'b10000 && weight >= cfgWeightMin &&
     ({1'b0, weight} + {1'b0, cfgStepUp}) <= {1'b0, cfgWeightMax})
    |=> ({1'b0, weight} == {1'b0, $past(weight)} + {1'b0, $past(cfgStepUp)}));
endmodule

// File: rtl/plastic_synapse.sv
module plastic_synapse import synPkg::*; #(
  parameter int W = 8,
  parameter int AGE_W = 8,
  parameter int CW = 16,
  parameter logic [W-1:0] RESET_WEIGHT = 8'd128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             preSpike,
  input  logic             postSpike,
  input  logic             tick,
  input  logic [W-1:0]     cfgStepUp,
  input  logic [W-1:0]     cfgStepDown,
  input  logic [AGE_W-1:0] cfgWindow,
  input  logic [W-1:0]     cfgWeightMin,
  input  logic [W-1:0]     cfgWeightMax,
  input  logic [CW-1:0]    cfgSetPoint,
  input  logic [W-1:0]     cfgHomeoStep,
  input  logic [CW-1:0]    cfgRatePeriod,
  input  logic [CW-1:0]    cfgDecayPeriod,
  output logic [W-1:0]     weight,
  output logic             atMax,
  output logic             atMin
);
  learnStrobes_t strobes;

  syn_ctrl #(.AGE_W(AGE_W), .CW(CW)) ctrl (
    .clk(clk), .rstN(rstN), .preSpike(preSpike), .postSpike(postSpike), .tick(tick),
    .cfgWindow(cfgWindow), .cfgSetPoint(cfgSetPoint), .cfgRatePeriod(cfgRatePeriod),
    .cfgDecayPeriod(cfgDecayPeriod), .strobes(strobes));

  syn_datapath #(.W(W), .RESET_WEIGHT(RESET_WEIGHT)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgStepUp(cfgStepUp),
    .cfgStepDown(cfgStepDown), .cfgHomeoStep(cfgHomeoStep),
    .cfgWeightMin(cfgWeightMin), .cfgWeightMax(cfgWeightMax), .weight(weight));

  assign atMax = (weight == cfgWeightMax);
  assign atMin = (weight == cfgWeightMin);
endmodule

// File: tb/plastic_synapse_test.sv
module plastic_synapse_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic preSpike = 0, postSpike = 0, tick = 0;
  logic [7:0]  cfgStepUp = 10, cfgStepDown = 6, cfgWindow = 4;
  logic [7:0]  cfgWeightMin = 20, cfgWeightMax = 200, cfgHomeoStep = 5;
  logic [15:0] cfgSetPoint = 1, cfgRatePeriod = 0, cfgDecayPeriod = 0;
  logic [7:0]  weight;
  logic        atMax, atMin;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  plastic_synapse uut (.*);

  // {pre, post, tick, expected weight}
  localparam int NV = 18;
  localparam logic [10:0] VEC [NV] = '{
    {3'b100, 8'd128},  // R4 first pre: post age 255, no pairing
    {3'b001, 8'd128},
    {3'b010, 8'd138},  // R2 pre age 1 < 4
    {3'b001, 8'd138},
    {3'b001, 8'd138},
    {3'b100, 8'd132},  // R3 post age 2 < 4
    {3'b001, 8'd132},
    {3'b001, 8'd132},
    {3'b001, 8'd132},
    {3'b100, 8'd132},  // R4 post age 5 outside
    {3'b001, 8'd132},
    {3'b001, 8'd132},
    {3'b001, 8'd132},
    {3'b001, 8'd132},
    {3'b010, 8'd132},  // R4 pre age exactly 4: edge, no pairing
    {3'b110, 8'd132},  // R5 coincident spikes hold
    {3'b010, 8'd142},  // R2 pre age 0 after coincidence
    {3'b100, 8'd136}   // R3 post age 0
  };

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic q, input logic t);
    @(negedge clk);
    preSpike = p; postSpike = q; tick = t;
    @(negedge clk);
    preSpike = 0; postSpike = 0; tick = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(weight, 128, "R1 weight in reset");
    rstN = 1;
    @(negedge clk);
    chk(weight, 128, "R1 weight after reset");
    chk(atMax, 0, "R7 atMax after reset");
    chk(atMin, 0, "R7 atMin after reset");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {preSpike, postSpike, tick} = VEC[i][10:8];
      @(negedge clk);
      {preSpike, postSpike, tick} = 3'b000;
      chk(weight, VEC[i][7:0], $sformatf("R2/R3 vector %0d", i));
    end

    // R6 R7 ceiling
    cfgStepUp = 100;
    doReset();
    step(1, 0, 0);
    step(0, 1, 0);
    chk(weight, 200, "R6 clamp at ceiling");
    chk(atMax, 1, "R7 atMax at ceiling");

    // R6 R7 floor
    cfgStepUp = 10; cfgStepDown = 150;
    doReset();
    step(0, 1, 0);
    step(1, 0, 0);
    chk(weight, 20, "R6 clamp at floor");
    chk(atMin, 1, "R7 atMin at floor");

    // R8 homeostasis
    cfgStepDown = 6; cfgRatePeriod = 4;
    doReset();
    step(0, 1, 0);
    step(0, 1, 0);
    for (int k = 0; k < 3; k++) step(0, 0, 1);
    chk(weight, 128, "R8 no step before period end");
    step(0, 0, 1);
    chk(weight, 123, "R8 rate above set point");
    for (int k = 0; k < 4; k++) step(0, 0, 1);
    chk(weight, 128, "R8 rate below set point");
    for (int k = 0; k < 3; k++) step(0, 0, 1);
    step(0, 1, 1);
    chk(weight, 128, "R8 rate equal set point, spike on final tick counted");

    // R9 decay
    cfgHomeoStep = 0; cfgDecayPeriod = 3; cfgWeightMin = 125;
    doReset();
    for (int k = 0; k < 2; k++) step(0, 0, 1);
    chk(weight, 128, "R9 no decay before period");
    step(0, 0, 1);
    chk(weight, 127, "R9 one LSB decay");
    for (int k = 0; k < 12; k++) step(0, 0, 1);
    chk(weight, 125, "R9 decay stops at floor");
    chk(atMin, 1, "R9 floor flag");

    cfgDecayPeriod = 0;
    doReset();
    for (int k = 0; k < 6; k++) step(0, 0, 1);
    chk(weight, 128, "R9 decay disabled at N=0");

    // R1 reset mid-run
    cfgStepUp = 30;
    step(1, 0, 0);
    step(0, 1, 0);
    chk(weight, 158, "R2 step before reset");
    doReset();
    chk(weight, 128, "R1 reset restores weight");
    step(0, 1, 0);
    chk(weight, 128, "R1 ages restored to 255, no pairing");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule